// File: doc/BRIEF.md
# On/Off-Time PWM Generator

This block produces one pulse-width-modulated output whose shape is set by two independent counts: the number of timebase ticks the output stays high, and the number of ticks it then stays low. The timebase is a one-cycle tick enable that the surrounding chip supplies at 1 MHz, so one count is one microsecond. Each count is 16 bits wide. Software writes each count one byte at a time through a plain synchronous write port and a combinational read port. The period is the sum of the two counts. Each period starts in the high phase, and the polarity never inverts.

A small configuration register holds three bits: run enable, mode, and external gating. While running, the block repeats high and low phases without end. When gating is set, the output is ANDed with an external input. Clearing the enable bit forces the output low at once, without waiting for the period to end. A state machine with three states (`ST_IDLE`, `ST_HIGH`, `ST_LOW`) keeps the phase. ST_IDLE goes to a fresh start when enable is seen. ST_HIGH goes to ST_LOW when the on count expires. ST_LOW goes to a fresh start when the off count expires. Any state goes to ST_IDLE when enable is clear. A fresh start loads shadow copies of both counts, clears the counter, and enters ST_HIGH, or ST_LOW if the on count is zero. With an off count of zero, expiry of the on count goes straight to a fresh start. The counts in use therefore change only at period boundaries.

Top module: `pwm_onoff_gen`

## Requirements
- R1: After reset every register reads 0 and `pwm_out` is low.
- R2: Byte addresses are fixed: 0 is configuration (bit 0 enable, bit 1 mode, bit 2 gating; other bits read 0); 1 and 2 are the on count, low then high byte; 3 and 4 are the off count, low then high byte. Each readable byte returns its last written value. Addresses 5 to 7 read 0.
- R3: A write that sets enable while idle makes `pwm_out` high from the second rising edge after the write. With a tick every cycle, sample k (k = 0 at that edge) is high exactly when k mod (on+off) < on. The period repeats with mode 0.
- R4: The phase counters advance only on clock edges where `tick` is high. Without ticks the output holds its level.
- R5: A write that clears enable drives `pwm_out` low in the first cycle after the write edge, even in mid-high-phase.
- R6: An on count of 0 keeps `pwm_out` low while enabled.
- R7: An off count of 0 with a nonzero on count keeps `pwm_out` high while enabled.
- R8: Count bytes written while enabled take effect only at the next period start.
- R9: With gating set, `pwm_out` equals the generated waveform ANDed with `ext_in`. With gating clear, `ext_in` has no effect.
- R10: While enable is clear, `pwm_out` stays low and the machine returns to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase enable, one count per high cycle |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| ext_in | input | 1 | External gating input |
| pwm_out | output | 1 | PWM output |

## Verification
The hardest case to reach from the ports is a count update that lands inside a running period. The old shadow values must finish that period, and the new ones must start at the boundary. The bench reaches it with a directed run: it rewrites the on count's low byte during the first high phase. It then compares each following cycle against a two-stage expected waveform. Seeded random runs cover many count pairs, including zeros and gating with random `ext_in`. Each run restarts from a disable, so the fresh-start behaviour is exercised every time.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } pwm_state_e;

    localparam int CFG_EN_BIT   = 0;
    localparam int CFG_MODE_BIT = 1;
    localparam int CFG_GATE_BIT = 2;
    localparam int CFG_BITS     = 3;
    localparam int CFG_ADDR     = 0;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              en,
    output logic              mode,
    output logic              gate_en,
    output logic [CNT_W-1:0]  on_val,
    output logic [CNT_W-1:0]  off_val
);
    localparam int NB       = CNT_W / 8;
    localparam int ON_BASE  = CFG_ADDR + 1;
    localparam int OFF_BASE = ON_BASE + NB;

    logic [CFG_BITS-1:0] cfg_q;
    logic [7:0]          on_q  [NB];
    logic [7:0]          off_q [NB];

    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (wr_en && addr == ADDR_W'(CFG_ADDR))
            cfg_q <= wdata[CFG_BITS-1:0];
    end

    for (genvar b = 0; b < NB; b++) begin : g_byte
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                on_q[b]  <= '0;
                off_q[b] <= '0;
            end else if (wr_en) begin
                if (addr == ADDR_W'(ON_BASE + b))
                    on_q[b] <= wdata;
                if (addr == ADDR_W'(OFF_BASE + b))
                    off_q[b] <= wdata;
            end
        end
        assign on_val[8*b +: 8]  = on_q[b];
        assign off_val[8*b +: 8] = off_q[b];
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(CFG_ADDR))
            rdata = {{(8-CFG_BITS){1'b0}}, cfg_q};
        for (int b = 0; b < NB; b++) begin
            if (addr == ADDR_W'(ON_BASE + b))
                rdata = on_q[b];
            if (addr == ADDR_W'(OFF_BASE + b))
                rdata = off_q[b];
        end
    end

    assign en      = cfg_q[CFG_EN_BIT];
    assign mode    = cfg_q[CFG_MODE_BIT];
    assign gate_en = cfg_q[CFG_GATE_BIT];
endmodule

// File: rtl/pwm_phase_fsm.sv
module pwm_phase_fsm
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             en,
    input  logic [CNT_W-1:0] on_val,
    input  logic [CNT_W-1:0] off_val,
    output logic             raw_high
);
    localparam int EXT_W = CNT_W + 1;

    pwm_state_e       state, state_d;
    logic [CNT_W-1:0] cnt, cnt_d, on_s, on_d, off_s, off_d;
    logic [EXT_W-1:0] cnt_inc;
    logic             restart;

    assign cnt_inc = {1'b0, cnt} + EXT_W'(1);

    always_comb begin
        state_d = state;
        cnt_d   = cnt;
        on_d    = on_s;
        off_d   = off_s;
        restart = 1'b0;
        unique case (state)
            ST_IDLE: begin
                cnt_d = '0;
                if (en) restart = 1'b1;
            end
            ST_HIGH: begin
                if (!en) begin
                    state_d = ST_IDLE;
                end else if (tick) begin
                    if (cnt_inc == {1'b0, on_s}) begin
                        if (off_s == '0) begin
                            restart = 1'b1;
                        end else begin
                            state_d = ST_LOW;
                            cnt_d   = '0;
                        end
                    end else begin
                        cnt_d = cnt_inc[CNT_W-1:0];
                    end
                end
            end
            ST_LOW: begin
                if (!en) begin
                    state_d = ST_IDLE;
                end else if (tick) begin
                    if (off_s == '0 || cnt_inc == {1'b0, off_s})
                        restart = 1'b1;
                    else
                        cnt_d = cnt_inc[CNT_W-1:0];
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (restart) begin
            on_d    = on_val;
            off_d   = off_val;
            cnt_d   = '0;
            state_d = (on_val == '0) ? ST_LOW : ST_HIGH;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            on_s  <= '0;
            off_s <= '0;
        end else begin
            state <= state_d;
            cnt   <= cnt_d;
            on_s  <= on_d;
            off_s <= off_d;
        end
    end

    always_comb begin
        raw_high = (state == ST_HIGH);
    end

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_HIGH) |-> (cnt < on_s)) and
        ((state == ST_LOW && off_s != '0) |-> (cnt < off_s)));

    assert_start_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_IDLE && state != ST_IDLE && on_s != '0) |-> (state == ST_HIGH));

    assert_hold_no_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && en && state != ST_IDLE) |=> ($stable(state) && $stable(cnt)));

    assert_zero_on_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && on_s == '0) |-> (state == ST_LOW));

    assert_off_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state == ST_IDLE));
endmodule

// File: rtl/pwm_onoff_gen.sv
module pwm_onoff_gen
    import pwm_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              ext_in,
    output logic              pwm_out
);
    logic             en, mode, gate_en, raw_high;
    logic [CNT_W-1:0] on_val, off_val;

    pwm_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .en      (en),
        .mode    (mode),
        .gate_en (gate_en),
        .on_val  (on_val),
        .off_val (off_val)
    );

    pwm_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .en       (en),
        .on_val   (on_val),
        .off_val  (off_val),
        .raw_high (raw_high)
    );

    // Enable gates the output directly, so a disable write takes effect in
    // the same cycle the register changes, ahead of the state machine.
    assign pwm_out = raw_high && en && (!gate_en || ext_in);

    logic unused_mode;
    assign unused_mode = mode;
endmodule

// File: tb/pwm_onoff_gen_tb.sv
module pwm_onoff_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       ext_in = 1'b0;
    logic       pwm_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwm_onoff_gen u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ext_in(ext_in), .pwm_out(pwm_out)
    );

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic bit wave(input int on, input int off, input int k);
        if (on == 0) return 1'b0;
        if (off == 0) return 1'b1;
        return (k % (on + off)) < on;
    endfunction

    task automatic set_counts(input int on, input int off);
        wr(3'd1, on[7:0]); wr(3'd2, on[15:8]);
        wr(3'd3, off[7:0]); wr(3'd4, off[15:8]);
    endtask

    initial begin
        int unsigned seed_set;
        seed_set = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        for (int a = 0; a < 8; a++) begin
            addr = a[2:0]; #1;
            check({8'h0, rdata}, 16'h0, "R1 reset read");
        end
        check({15'h0, pwm_out}, 16'h0, "R1 reset out");

        // R2: readback and unmapped addresses
        wr(3'd0, 8'hFA); wr(3'd1, 8'h5C); wr(3'd2, 8'hA3); wr(3'd3, 8'h11); wr(3'd4, 8'hE7);
        wr(3'd5, 8'hFF); wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
        addr = 3'd0; #1; check({8'h0, rdata}, 16'h0002, "R2 cfg mode bit");
        addr = 3'd1; #1; check({8'h0, rdata}, 16'h005C, "R2 on low");
        addr = 3'd2; #1; check({8'h0, rdata}, 16'h00A3, "R2 on high");
        addr = 3'd3; #1; check({8'h0, rdata}, 16'h0011, "R2 off low");
        addr = 3'd4; #1; check({8'h0, rdata}, 16'h00E7, "R2 off high");
        for (int a = 5; a < 8; a++) begin
            addr = a[2:0]; #1; check({8'h0, rdata}, 16'h0, "R2 unmapped");
        end
        wr(3'd0, 8'h00);

        // R3: basic waveform, on=3 off=2
        set_counts(3, 2);
        wr(3'd0, 8'h01);
        for (int k = 0; k < 15; k++) begin
            @(negedge clk); #1;
            check({15'h0, pwm_out}, {15'h0, wave(3, 2, k)}, "R3 waveform");
        end

        // R5 and R10: immediate disable in high phase
        wr(3'd0, 8'h00);
        set_counts(20, 2);
        wr(3'd0, 8'h01);
        repeat (3) @(negedge clk);
        #1; check({15'h0, pwm_out}, 16'h1, "R5 high before disable");
        wr(3'd0, 8'h00); #1;
        check({15'h0, pwm_out}, 16'h0, "R5 low right after disable");
        for (int k = 0; k < 5; k++) begin
            @(negedge clk); #1;
            check({15'h0, pwm_out}, 16'h0, "R10 stays low");
        end

        // R4: no ticks holds the phase
        set_counts(2, 2);
        tick = 1'b0;
        wr(3'd0, 8'h01);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk); #1;
            check({15'h0, pwm_out}, 16'h1, "R4 hold without tick");
        end
        tick = 1'b1;
        for (int j = 1; j < 8; j++) begin
            @(negedge clk); #1;
            check({15'h0, pwm_out}, {15'h0, wave(2, 2, j)}, "R4 resume on tick");
        end
        wr(3'd0, 8'h00);

        // R6 and R7: zero counts
        set_counts(0, 3);
        wr(3'd0, 8'h01);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk); #1; check({15'h0, pwm_out}, 16'h0, "R6 zero on");
        end
        wr(3'd0, 8'h00);
        set_counts(2, 0);
        wr(3'd0, 8'h01);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk); #1; check({15'h0, pwm_out}, 16'h1, "R7 zero off");
        end
        wr(3'd0, 8'h00);

        // R8: on count rewritten during first high phase
        set_counts(3, 2);
        wr(3'd0, 8'h01);
        @(negedge clk); #1;
        check({15'h0, pwm_out}, 16'h1, "R8 k0");
        wr_en = 1'b1; addr = 3'd1; wdata = 8'd5;
        for (int k = 1; k < 26; k++) begin
            bit e;
            @(negedge clk);
            wr_en = 1'b0;
            #1;
            e = (k < 5) ? (k < 3) : (((k - 5) % 7) < 5);
            check({15'h0, pwm_out}, {15'h0, e}, "R8 update at boundary");
        end
        wr(3'd0, 8'h00);

        // R3, R6, R7, R9: seeded random runs
        for (int it = 0; it < 60; it++) begin
            int on, off;
            bit gate;
            on   = ($urandom % 5 == 0) ? 0 : 1 + $urandom % 9;
            off  = ($urandom % 5 == 0) ? 0 : 1 + $urandom % 9;
            gate = $urandom % 2;
            wr(3'd0, 8'h00);
            set_counts(on, off);
            wr(3'd0, {5'b0, gate, 2'b01});
            for (int k = 0; k < 30; k++) begin
                bit e;
                @(negedge clk);
                ext_in = $urandom % 2;
                #1;
                e = wave(on, off, k) && (!gate || ext_in);
                check({15'h0, pwm_out}, {15'h0, e}, gate ? "R9 gated wave" : "R3 R9 ungated wave");
            end
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule